// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns an 18-bit virtual address into a 20-bit physical address. The virtual address is split into a 9-bit virtual page number and a 9-bit page offset. The physical address is an 11-bit frame number followed by the unchanged offset. Translation goes through up to three tiers, always in the same order:

- a 16-entry direct-mapped lookaside buffer;
- a flat page table with one entry per virtual page;
- a fault handshake with an external frame loader.

A fault fills both the page table and the buffer. A page table hit refills the buffer. Pages are never evicted from the table.

The block handles one request at a time. The requester offers an address on a wide input bus when `in_ready` is high. Some cycles later it receives a one-cycle `out_done` pulse. The pulse carries the physical address and a 2-bit code that says where the translation came from. If any bus bit above the 18 address bits is set, the request is rejected as illegal and changes no state.

Top module: `pat_top`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_done` and `flt_req` are 0. Every buffer and page table entry is invalid, so the first access to any page raises a fault.
- R2: For a legal request, `out_pa` equals the frame number concatenated with the request's low 9 address bits. A request is legal when bits [IN_W-1:18] of `in_addr` are all zero.
- R3: A request hits the buffer when the entry selected by page-number bits [3:0] is valid and its stored tag equals page-number bits [8:4]. A buffer hit completes with `out_src` = 0 and no fault request.
- R4: A request that misses the buffer but finds a valid page table entry completes with `out_src` = 1. It also rewrites the buffer entry at that index, so a repeat of the same page completes with `out_src` = 0.
- R5: On a miss in both tiers, the block raises `flt_req` with `flt_vpn` equal to the page number. Both are held until the cycle `flt_ack` is high. The `flt_ppn` value sampled in that cycle becomes the frame number in both tiers, and the request completes with `out_src` = 2.
- R6: Two pages with equal page-number bits [3:0] evict each other from the buffer, while both stay valid in the page table.
- R7: Each accepted request produces exactly one `out_done` pulse, one cycle long. `out_src` encodes 0 = buffer, 1 = table, 2 = fault, 3 = illegal.
- R8: An illegal request completes with `out_src` = 3 and `out_pa` = 0. It raises no fault and leaves the buffer and the table unchanged.
- R9: `in_ready` is low from acceptance until completion. `in_valid` in that window is ignored.
- R10: `flt_ack` outside a pending fault has no effect: it produces no completion and loads no page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, taken when `in_ready` is high |
| in_addr | input | IN_W (24) | Request address bus; bits above 17 must be zero |
| in_ready | output | 1 | Block idle and able to accept a request |
| out_done | output | 1 | One-cycle completion pulse |
| out_src | output | 2 | Source code of the completed translation |
| out_pa | output | 20 | Physical address (0 for illegal requests) |
| flt_req | output | 1 | Page fault request to the frame loader |
| flt_vpn | output | 9 | Faulting virtual page number |
| flt_ack | input | 1 | Frame loader response strobe |
| flt_ppn | input | 11 | Frame number returned with `flt_ack` |

## Verification
The bench builds the block with its default parameters: a 24-bit input bus, a 16-entry buffer, and 512 pages of 11-bit frames. With a 16-entry buffer, sweeping 48 pages forces every index to be evicted several times. The flat 512-entry table keeps all of those pages resident, so table refills after buffer conflicts and the topmost page 0x1FF are both reached within a few hundred requests. The six spare bus bits leave room to test illegal requests against both resident and unloaded pages.

// File: rtl/pat_pkg.sv
package pat_pkg;

    // Completion source codes
    typedef enum logic [1:0] {
        SRC_TLB     = 2'd0,
        SRC_TABLE   = 2'd1,
        SRC_FAULT   = 2'd2,
        SRC_ILLEGAL = 2'd3
    } xlat_src_e;

    // Control sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_FAULT = 2'd2
    } ctl_state_e;

    // True when any bit at or above position lo of a wide bus is set
    function automatic logic upper_set(input logic [63:0] bus, input int lo);
        logic r;
        r = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (i >= lo && bus[i]) r = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pat_tlb.sv
module pat_tlb #(
    parameter int VPN_W = 9,
    parameter int PPN_W = 11,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn
);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;

    tlb_ent_t ent [DEPTH];

    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;

    assign wr_idx = wr_vpn[IDX_W-1:0];
    assign wr_tag = wr_vpn[VPN_W-1:IDX_W];
    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ent[g].vld <= 1'b1;
                ent[g].tag <= wr_tag;
                ent[g].ppn <= wr_ppn;
            end
        end
    end

    tlb_ent_t sel;
    always_comb begin
        sel    = ent[lk_idx];
        lk_hit = sel.vld && (sel.tag == lk_tag);
        lk_ppn = sel.ppn;
    end

endmodule

// File: rtl/pat_ptab.sv
module pat_ptab #(
    parameter int VPN_W = 9,
    parameter int PPN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn
);
    localparam int PAGES = 1 << VPN_W;

    logic [PAGES-1:0] vld_q;
    logic [PPN_W-1:0] frame_q [PAGES];

    // Valid bits are reset; once set they are never cleared
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_vpn] <= 1'b1;
        end
    end

    // Frame storage needs no reset: it is qualified by the valid bit
    always_ff @(posedge clk) begin
        if (wr_en) begin
            frame_q[wr_vpn] <= wr_ppn;
        end
    end

    assign lk_hit = vld_q[lk_vpn];
    assign lk_ppn = frame_q[lk_vpn];

endmodule

// File: rtl/pat_ctrl.sv
module pat_ctrl
    import pat_pkg::*;
#(
    parameter int VPN_W = 9,
    parameter int OFF_W = 9,
    parameter int PPN_W = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [VPN_W-1:0]       in_vpn,
    input  logic [OFF_W-1:0]       in_off,
    input  logic                   in_bad,
    output logic                   in_ready,
    output logic [VPN_W-1:0]       lk_vpn,
    input  logic                   tlb_hit,
    input  logic [PPN_W-1:0]       tlb_ppn,
    input  logic                   pt_hit,
    input  logic [PPN_W-1:0]       pt_ppn,
    output logic                   tlb_wr,
    output logic                   pt_wr,
    output logic [PPN_W-1:0]       wr_ppn,
    output logic                   flt_req,
    output logic [VPN_W-1:0]       flt_vpn,
    input  logic                   flt_ack,
    input  logic [PPN_W-1:0]       flt_ppn,
    output logic                   out_done,
    output xlat_src_e              out_src,
    output logic [PPN_W+OFF_W-1:0] out_pa
);
    localparam int PA_W = PPN_W + OFF_W;

    ctl_state_e       state_q;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic             bad_q;
    logic             done_q;
    xlat_src_e        src_q;
    logic [PA_W-1:0]  pa_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
            off_q   <= '0;
            bad_q   <= 1'b0;
            done_q  <= 1'b0;
            src_q   <= SRC_TLB;
            pa_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        vpn_q   <= in_vpn;
                        off_q   <= in_off;
                        bad_q   <= in_bad;
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (bad_q) begin
                        done_q  <= 1'b1;
                        src_q   <= SRC_ILLEGAL;
                        pa_q    <= '0;
                        state_q <= ST_IDLE;
                    end else if (tlb_hit) begin
                        done_q  <= 1'b1;
                        src_q   <= SRC_TLB;
                        pa_q    <= {tlb_ppn, off_q};
                        state_q <= ST_IDLE;
                    end else if (pt_hit) begin
                        done_q  <= 1'b1;
                        src_q   <= SRC_TABLE;
                        pa_q    <= {pt_ppn, off_q};
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_FAULT;
                    end
                end
                ST_FAULT: begin
                    if (flt_ack) begin
                        done_q  <= 1'b1;
                        src_q   <= SRC_FAULT;
                        pa_q    <= {flt_ppn, off_q};
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    logic look_refill;
    logic fault_fill;

    always_comb begin
        look_refill = (state_q == ST_LOOK) && !bad_q && !tlb_hit && pt_hit;
        fault_fill  = (state_q == ST_FAULT) && flt_ack;
        tlb_wr      = look_refill || fault_fill;
        pt_wr       = fault_fill;
        wr_ppn      = fault_fill ? flt_ppn : pt_ppn;
    end

    assign in_ready = (state_q == ST_IDLE);
    assign lk_vpn   = vpn_q;
    assign flt_req  = (state_q == ST_FAULT);
    assign flt_vpn  = vpn_q;
    assign out_done = done_q;
    assign out_src  = src_q;
    assign out_pa   = pa_q;

endmodule

// File: rtl/pat_top.sv
module pat_top
    import pat_pkg::*;
#(
    parameter int IN_W      = 24,
    parameter int VPN_W     = 9,
    parameter int OFF_W     = 9,
    parameter int PPN_W     = 11,
    parameter int TLB_IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [IN_W-1:0]        in_addr,
    output logic                   in_ready,
    output logic                   out_done,
    output logic [1:0]             out_src,
    output logic [PPN_W+OFF_W-1:0] out_pa,
    output logic                   flt_req,
    output logic [VPN_W-1:0]       flt_vpn,
    input  logic                   flt_ack,
    input  logic [PPN_W-1:0]       flt_ppn
);
    localparam int VA_W = VPN_W + OFF_W;

    logic             in_bad;
    logic [VPN_W-1:0] in_vpn;
    logic [OFF_W-1:0] in_off;

    assign in_off = in_addr[OFF_W-1:0];
    assign in_vpn = in_addr[VA_W-1:OFF_W];

    if (IN_W > VA_W) begin : g_wide
        assign in_bad = upper_set(64'(in_addr), VA_W);
    end else begin : g_exact
        assign in_bad = 1'b0;
    end

    logic [VPN_W-1:0] lk_vpn;
    logic             tlb_hit;
    logic [PPN_W-1:0] tlb_ppn;
    logic             pt_hit;
    logic [PPN_W-1:0] pt_ppn;
    logic             tlb_wr;
    logic             pt_wr;
    logic [PPN_W-1:0] wr_ppn;
    xlat_src_e        src_e;

    pat_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(TLB_IDX_W)) tlb_i (
        .clk    (clk),
        .rst    (rst),
        .lk_vpn (lk_vpn),
        .lk_hit (tlb_hit),
        .lk_ppn (tlb_ppn),
        .wr_en  (tlb_wr),
        .wr_vpn (lk_vpn),
        .wr_ppn (wr_ppn)
    );

    pat_ptab #(.VPN_W(VPN_W), .PPN_W(PPN_W)) ptab_i (
        .clk    (clk),
        .rst    (rst),
        .lk_vpn (lk_vpn),
        .lk_hit (pt_hit),
        .lk_ppn (pt_ppn),
        .wr_en  (pt_wr),
        .wr_vpn (lk_vpn),
        .wr_ppn (wr_ppn)
    );

    pat_ctrl #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_vpn   (in_vpn),
        .in_off   (in_off),
        .in_bad   (in_bad),
        .in_ready (in_ready),
        .lk_vpn   (lk_vpn),
        .tlb_hit  (tlb_hit),
        .tlb_ppn  (tlb_ppn),
        .pt_hit   (pt_hit),
        .pt_ppn   (pt_ppn),
        .tlb_wr   (tlb_wr),
        .pt_wr    (pt_wr),
        .wr_ppn   (wr_ppn),
        .flt_req  (flt_req),
        .flt_vpn  (flt_vpn),
        .flt_ack  (flt_ack),
        .flt_ppn  (flt_ppn),
        .out_done (out_done),
        .out_src  (src_e),
        .out_pa   (out_pa)
    );

    assign out_src = src_e;

endmodule

// File: rtl/pat_chk.sv
module pat_chk #(
    parameter int VPN_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_done,
    input logic [1:0]       out_src,
    input logic             flt_req,
    input logic [VPN_W-1:0] flt_vpn,
    input logic             flt_ack
);
    // R5
    flt_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        flt_req && !flt_ack |=> flt_req);

    // R5
    flt_vpn_stable_chk: assert property (@(posedge clk) disable iff (rst)
        flt_req && !flt_ack |=> $stable(flt_vpn));

    // R5
    fault_src_ack_chk: assert property (@(posedge clk) disable iff (rst)
        out_done && out_src == 2'd2 |-> $past(flt_ack) && $past(flt_req));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    // R8
    illegal_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        out_done && out_src == 2'd3 |-> !$past(flt_req));

    // R9
    busy_in_fault_chk: assert property (@(posedge clk) disable iff (rst)
        flt_req |-> !in_ready);

endmodule

bind pat_top pat_chk #(.VPN_W(VPN_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .out_done (out_done),
    .out_src  (out_src),
    .flt_req  (flt_req),
    .flt_vpn  (flt_vpn),
    .flt_ack  (flt_ack)
);

// File: tb/pat_top_tb_top.sv
module pat_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [23:0] in_addr;
    logic        in_ready;
    logic        out_done;
    logic [1:0]  out_src;
    logic [19:0] out_pa;
    logic        flt_req;
    logic [8:0]  flt_vpn;
    logic        flt_ack;
    logic [10:0] flt_ppn;

    always #10 clk = ~clk;

    pat_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_addr  (in_addr),
        .in_ready (in_ready),
        .out_done (out_done),
        .out_src  (out_src),
        .out_pa   (out_pa),
        .flt_req  (flt_req),
        .flt_vpn  (flt_vpn),
        .flt_ack  (flt_ack),
        .flt_ppn  (flt_ppn)
    );

    int checks = 0;
    int errors = 0;

    // Reference model built from the requirements
    bit         m_tv [16];
    logic [4:0] m_tt [16];
    bit         m_pv [512];

    function automatic logic [10:0] ppn_of(input logic [8:0] v);
        return 11'(v) * 11'd7 + 11'h123;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Issue one request and answer any fault; optionally poke in_valid while busy
    task automatic xlate(input logic [23:0] addr, input bit poke, input logic [23:0] poke_addr,
                         output int src, output int pa, output int nflt, output int fvpn);
        int  n    = 0;
        int  wait_c = 0;
        bit  dn   = 0;
        bit  poked = 0;
        nflt = 0;
        fvpn = -1;
        src  = -1;
        pa   = -1;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_addr  = addr;
        @(negedge clk);
        in_valid = 1'b0;
        while (!dn && n < 100) begin
            @(negedge clk);
            n++;
            if (poked && in_valid) in_valid = 1'b0;
            if (flt_ack) flt_ack = 1'b0;
            if (out_done) begin
                dn  = 1;
                src = int'(out_src);
                pa  = int'(out_pa);
            end else if (flt_req) begin
                if (poke && !poked) begin
                    chk("R9", "in_ready while fault pending", int'(in_ready), 0);
                    in_valid = 1'b1;
                    in_addr  = poke_addr;
                    poked    = 1;
                end
                wait_c++;
                if (wait_c == 3) begin
                    fvpn    = int'(flt_vpn);
                    flt_ppn = ppn_of(flt_vpn);
                    flt_ack = 1'b1;
                    nflt++;
                    wait_c  = 0;
                end
            end
        end
        in_valid = 1'b0;
        if (!dn) chk("R7", "completion timeout", 0, 1);
    endtask

    // Predict, run and check one request; returns the observed source
    task automatic expect_xlate(input logic [23:0] addr, output int got_src);
        logic       bad;
        logic [8:0] vpn;
        logic [8:0] off;
        int         e_src;
        int         e_pa;
        int         pa;
        int         nflt;
        int         fvpn;
        string      rq;
        bad = |addr[23:18];
        vpn = addr[17:9];
        off = addr[8:0];
        if (bad) begin
            e_src = 3; e_pa = 0; rq = "R8";
        end else if (m_tv[vpn[3:0]] && m_tt[vpn[3:0]] == vpn[8:4]) begin
            e_src = 0; e_pa = int'({ppn_of(vpn), off}); rq = "R3";
        end else if (m_pv[vpn]) begin
            e_src = 1; e_pa = int'({ppn_of(vpn), off}); rq = "R4";
        end else begin
            e_src = 2; e_pa = int'({ppn_of(vpn), off}); rq = "R5";
        end
        xlate(addr, 1'b0, 24'h0, got_src, pa, nflt, fvpn);
        chk(rq, $sformatf("source for 0x%0h", addr), got_src, e_src);
        chk("R2", $sformatf("pa for 0x%0h", addr), pa, e_pa);
        chk(rq, "fault count", nflt, (e_src == 2) ? 1 : 0);
        if (e_src == 2) chk("R5", "faulting vpn", fvpn, int'(vpn));
        if (!bad) begin
            m_tv[vpn[3:0]] = 1'b1;
            m_tt[vpn[3:0]] = vpn[8:4];
            m_pv[vpn]      = 1'b1;
        end
    endtask

    task automatic t_reset();
        chk("R1", "in_ready after reset", int'(in_ready), 1);
        chk("R1", "out_done after reset", int'(out_done), 0);
        chk("R1", "flt_req after reset", int'(flt_req), 0);
    endtask

    task automatic t_same_page();
        int s;
        expect_xlate(24'h00007e, s);
        chk("R1", "first access faults", s, 2);
        expect_xlate(24'h00007f, s);
        chk("R3", "same page hits buffer", s, 0);
    endtask

    task automatic t_conflict();
        int s;
        expect_xlate(24'h004269, s);
        chk("R6", "page 0x21 first", s, 2);
        expect_xlate(24'h0003e9, s);
        chk("R6", "page 0x01 first", s, 2);
        expect_xlate(24'h004269, s);
        chk("R6", "page 0x21 evicted, table keeps it", s, 1);
        expect_xlate(24'h004269, s);
        chk("R4", "refilled buffer hits", s, 0);
        expect_xlate(24'h0003e9, s);
        chk("R6", "page 0x01 evicted, table keeps it", s, 1);
    endtask

    task automatic t_illegal();
        int s;
        expect_xlate(24'h10007e, s);
        chk("R8", "illegal over resident page", s, 3);
        expect_xlate(24'h00007e, s);
        chk("R8", "resident page still in buffer", s, 0);
        expect_xlate(24'h80aa00, s);
        chk("R8", "illegal over unloaded page", s, 3);
        expect_xlate(24'h00aa00, s);
        chk("R8", "unloaded page still faults", s, 2);
    endtask

    task automatic t_top_page();
        int s;
        expect_xlate(24'h03ffff, s);
        chk("R2", "top page faults", s, 2);
        expect_xlate(24'h03fe00, s);
        chk("R3", "top page buffer hit", s, 0);
    endtask

    task automatic t_sweep();
        int s;
        for (int v = 0; v < 48; v++) expect_xlate(24'((v << 9) | v), s);
        for (int v = 0; v < 48; v++) expect_xlate(24'((v << 9) | (511 - v)), s);
    endtask

    task automatic t_busy();
        int s;
        int pa;
        int nflt;
        int fvpn;
        int extra = 0;
        xlate(24'h00c010, 1'b1, 24'h00c210, s, pa, nflt, fvpn);
        chk("R9", "busy request source", s, 2);
        chk("R9", "busy request pa", pa, int'({ppn_of(9'h060), 9'h010}));
        m_tv[0] = 1'b1; m_tt[0] = 5'h06; m_pv[9'h060] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (out_done) extra++;
        end
        chk("R9", "no completion for ignored request", extra, 0);
        expect_xlate(24'h00c210, s);
        chk("R9", "ignored page still unloaded", s, 2);
    endtask

    task automatic t_stray_ack();
        int s;
        int extra = 0;
        @(negedge clk);
        flt_ppn = 11'h7ff;
        flt_ack = 1'b1;
        @(negedge clk);
        flt_ack = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (out_done) extra++;
            @(negedge clk);
        end
        chk("R10", "stray ack completions", extra, 0);
        expect_xlate(24'h00e005, s);
        chk("R10", "page after stray ack faults", s, 2);
    endtask

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_addr  = '0;
        flt_ack  = 1'b0;
        flt_ppn  = '0;
        for (int i = 0; i < 16; i++) begin m_tv[i] = 0; m_tt[i] = '0; end
        for (int i = 0; i < 512; i++) m_pv[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_same_page();
        t_conflict();
        t_illegal();
        t_top_page();
        t_busy();
        t_stray_ack();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog: got 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule